// File: doc/BRIEF.md
# Configurable Interrupt Pin Controller

This block merges three event sources into a single interrupt pin: a watchdog timeout, an alarm match and a power-fail warning. Each source arrives as a one-cycle strobe and sets its own sticky flag. The flag is set whether or not the source is allowed to reach the pin. A byte-wide control register holds one enable per source, a drive-mode bit and a timing-mode bit. Software reads the flags through a read strobe, and that read clears them.

The pin can be driven two ways. It can be push-pull and active high, or open-drain and active low, in which case the output-enable carries the interrupt and the data line stays low. It can also behave two ways in time. In level mode it stays active while any enabled flag is set, which means until software reads the flags. In pulse mode an enabled event holds it active for a fixed number of ticks from an external tick input, and a further enabled event restarts that count.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After a synchronous reset, the control register reads 0x20 and the flags read 0x00. The pin is then push-pull and inactive, so `irq_pin_o` is 0 and `irq_pin_oe` is 1.
- R2: A strobe on `ev_wdog`, `ev_alarm` or `ev_pfail` sets flag bit 0, 1 or 2 of `flag_rdata` at the next clock edge. The flag stays set until a flags read, whatever the enables are. Bits 7..3 of `flag_rdata` read 0.
- R3: An event whose enable bit is 0 sets its flag but leaves the pin inactive.
- R4: A cycle with `flag_rd` high clears all flags at the next edge. An event strobe in that same cycle still leaves its own flag set.
- R5: In level mode (control bit 4 = 0), the pin is active exactly while some flag is 1 and its matching enable bit is also 1. It stays active until a flags read.
- R6: In pulse mode (control bit 4 = 1), an enabled event makes the pin active from the next edge. The pin then stays active until `PULSE_TICKS` edges with `tick` high have passed, and a flags read does not end it early.
- R7: In pulse mode, an enabled event during an active pulse reloads the full count of `PULSE_TICKS` ticks.
- R8: With control bit 5 = 1, `irq_pin_oe` is 1 and `irq_pin_o` carries the active level. With bit 5 = 0, `irq_pin_o` is 0 and `irq_pin_oe` is 1 only while the pin is active.
- R9: A write with `cfg_wr_en` stores the byte at the next edge. Bits 0, 1 and 2 are the enables for watchdog, alarm and power fail, bit 4 is the timing mode and bit 5 is the drive mode. Bits 7, 6 and 3 always read 0. Enables and modes take effect for events from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| flag_rd | input | 1 | Flags read strobe, clears the flags |
| flag_rdata | output | 8 | Current flags (bits 2..0) |
| ev_wdog | input | 1 | Watchdog timeout strobe |
| ev_alarm | input | 1 | Alarm match strobe |
| ev_pfail | input | 1 | Power-fail strobe |
| tick | input | 1 | Time base for the pulse width |
| irq_pin_o | output | 1 | Pin data output |
| irq_pin_oe | output | 1 | Pin output enable |

## Verification
The hardest situations to reach are the ones where several things coincide. One is a flags read that arrives in the same cycle as a fresh event. Another is a retrigger that lands in the middle of a pulse. A third is a mode or enable write that races an event strobe.

Directed sequences drive the read-with-event and the retrigger cycles exactly. Random traffic is then weighted so that events, ticks, reads and control writes overlap often. A cycle-level reference model in the bench tracks every overlap.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_WDOG  = 2'd0,
        SRC_ALARM = 2'd1,
        SRC_PFAIL = 2'd2
    } irq_src_e;

    localparam int BIT_PULSE = 4;
    localparam int BIT_POL   = 5;

    localparam logic [7:0] CFG_RESET = 8'h20;
    localparam logic [7:0] CFG_MASK  = 8'h37;

    typedef struct packed {
        logic               pol_high;
        logic               pulse_mode;
        logic [NUM_SRC-1:0] en;
    } irq_cfg_t;

    typedef struct packed {
        logic data;
        logic oe;
    } pin_drv_t;

    function automatic irq_cfg_t cfg_unpack(input logic [7:0] b);
        irq_cfg_t c;
        c.pol_high   = b[BIT_POL];
        c.pulse_mode = b[BIT_PULSE];
        c.en         = b[NUM_SRC-1:0];
        return c;
    endfunction

    function automatic pin_drv_t pin_encode(input logic active, input logic pol_high);
        pin_drv_t d;
        if (pol_high) begin
            d.data = active;
            d.oe   = 1'b1;
        end else begin
            d.data = 1'b0;
            d.oe   = active;
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
    import irq_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output irq_cfg_t   cfg,
    output logic [7:0] rdata
);

    logic [7:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            cfg_q <= wdata & CFG_MASK;
        end
    end

    assign rdata = cfg_q;
    assign cfg   = cfg_unpack(cfg_q);

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic         rd_clr,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (ev[i]) begin
                flag_q <= 1'b1;
            end else if (rd_clr) begin
                flag_q <= 1'b0;
            end
        end
        assign flags[i] = flag_q;
    end

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
    parameter int PULSE_TICKS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic tick,
    output logic busy
);

    localparam int CNT_W = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/irq_pin_driver.sv
module irq_pin_driver
    import irq_pin_pkg::*;
(
    input  logic active,
    input  logic pol_high,
    output logic pin_o,
    output logic pin_oe
);

    pin_drv_t drv;

    always_comb begin
        drv    = pin_encode(active, pol_high);
        pin_o  = drv.data;
        pin_oe = drv.oe;
    end

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_pin_pkg::*;
#(
    parameter int PULSE_TICKS = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr_en,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       flag_rd,
    output logic [7:0] flag_rdata,
    input  logic       ev_wdog,
    input  logic       ev_alarm,
    input  logic       ev_pfail,
    input  logic       tick,
    output logic       irq_pin_o,
    output logic       irq_pin_oe
);

    irq_cfg_t           cfg;
    logic [NUM_SRC-1:0] ev_vec;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] hit;
    logic               pulse_load;
    logic               pulse_busy;
    logic               level_act;
    logic               pin_active;

    always_comb begin
        ev_vec            = '0;
        ev_vec[SRC_WDOG]  = ev_wdog;
        ev_vec[SRC_ALARM] = ev_alarm;
        ev_vec[SRC_PFAIL] = ev_pfail;
    end

    irq_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    irq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev_vec),
        .rd_clr (flag_rd),
        .flags  (flags)
    );

    assign hit        = ev_vec & cfg.en;
    assign pulse_load = cfg.pulse_mode & (|hit);

    irq_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk  (clk),
        .rst  (rst),
        .load (pulse_load),
        .tick (tick),
        .busy (pulse_busy)
    );

    assign level_act  = |(flags & cfg.en);
    assign pin_active = cfg.pulse_mode ? pulse_busy : level_act;

    irq_pin_driver u_drv (
        .active   (pin_active),
        .pol_high (cfg.pol_high),
        .pin_o    (irq_pin_o),
        .pin_oe   (irq_pin_oe)
    );

    assign flag_rdata = {{(8-NUM_SRC){1'b0}}, flags};

endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr_en,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       flag_rd,
    input logic [7:0] flag_rdata,
    input logic       ev_wdog,
    input logic       ev_alarm,
    input logic       ev_pfail,
    input logic       tick,
    input logic       irq_pin_o,
    input logic       irq_pin_oe
);

    logic       seen_act;
    logic [2:0] ev_v;

    assign seen_act = cfg_rdata[5] ? irq_pin_o : irq_pin_oe;
    assign ev_v     = {ev_pfail, ev_alarm, ev_wdog};

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cfg_rdata == 8'h20) && (flag_rdata == 8'h00));

    // R2: each strobe sets its flag
    a_r2_wdog_sets: assert property (@(posedge clk) disable iff (rst)
        ev_wdog |=> flag_rdata[0]);
    a_r2_alarm_sets: assert property (@(posedge clk) disable iff (rst)
        ev_alarm |=> flag_rdata[1]);
    a_r2_pfail_sets: assert property (@(posedge clk) disable iff (rst)
        ev_pfail |=> flag_rdata[2]);

    // R4: a read with no event empties the flags
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && (ev_v == 3'b000)) |=> (flag_rdata == 8'h00));

    // R3 and R5: level mode stays quiet when no enabled flag is set
    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata[4] && ((flag_rdata[2:0] & cfg_rdata[2:0]) == 3'b000)) |-> !seen_act);

    // R6: an enabled event in pulse mode activates the pin
    a_r6_pulse_arms: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[4] && ((ev_v & cfg_rdata[2:0]) != 3'b000) && !cfg_wr_en) |=> seen_act);

    // R8: drive-mode encoding
    a_r8_od_data_low: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[5] |-> !irq_pin_o);
    a_r8_pp_oe_on: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[5] |-> irq_pin_oe);

    // R9: reserved bits read zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[7:6] == 2'b00) && !cfg_rdata[3]);

    // R2: upper flag bits read zero
    a_r2_flag_upper_zero: assert property (@(posedge clk) disable iff (rst)
        flag_rdata[7:3] == 5'b00000);

endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk u_chk (.*);

// File: tb/irq_pin_ctrl_tb.sv
module irq_pin_ctrl_tb;

    localparam int PT = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr_en;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       flag_rd;
    logic [7:0] flag_rdata;
    logic       ev_wdog;
    logic       ev_alarm;
    logic       ev_pfail;
    logic       tick;
    logic       irq_pin_o;
    logic       irq_pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] m_cfg;
    logic [2:0] m_fl;
    int         m_cnt;

    always #2 clk = ~clk;

    irq_pin_ctrl #(.PULSE_TICKS(PT)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .flag_rd    (flag_rd),
        .flag_rdata (flag_rdata),
        .ev_wdog    (ev_wdog),
        .ev_alarm   (ev_alarm),
        .ev_pfail   (ev_pfail),
        .tick       (tick),
        .irq_pin_o  (irq_pin_o),
        .irq_pin_oe (irq_pin_oe)
    );

    function automatic logic exp_active();
        if (m_cfg[4]) return (m_cnt != 0);
        return |(m_fl & m_cfg[2:0]);
    endfunction

    function automatic logic exp_pin_o();
        return m_cfg[5] ? exp_active() : 1'b0;
    endfunction

    function automatic logic exp_oe();
        return m_cfg[5] ? 1'b1 : exp_active();
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        logic [2:0] ev;
        logic [2:0] hit;
        ev  = {ev_pfail, ev_alarm, ev_wdog};
        hit = ev & m_cfg[2:0];
        if (rst) begin
            m_cfg = 8'h20;
            m_fl  = 3'b000;
            m_cnt = 0;
        end else begin
            if (m_cfg[4] && hit != 3'b000) m_cnt = PT;
            else if (tick && m_cnt != 0) m_cnt = m_cnt - 1;
            if (flag_rd) m_fl = 3'b000;
            m_fl = m_fl | ev;
            if (cfg_wr_en) m_cfg = cfg_wdata & 8'h37;
        end
    endtask

    task automatic step(input string pin_req);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check("R9", "cfg_rdata", cfg_rdata, m_cfg);
        check("R2", "flag_rdata", flag_rdata, {5'b0, m_fl});
        check(pin_req, "irq_pin_o", {7'b0, irq_pin_o}, {7'b0, exp_pin_o()});
        check(pin_req, "irq_pin_oe", {7'b0, irq_pin_oe}, {7'b0, exp_oe()});
    endtask

    task automatic idle();
        cfg_wr_en = 0; flag_rd = 0; tick = 0;
        ev_wdog = 0; ev_alarm = 0; ev_pfail = 0;
    endtask

    task automatic write_cfg(input logic [7:0] v, input string req);
        cfg_wr_en = 1; cfg_wdata = v;
        step(req);
        cfg_wr_en = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cfg = 8'h00; m_fl = 3'b000; m_cnt = 0;
        cfg_wdata = 8'h00;
        idle();
        rst = 1;
        @(negedge clk);
        step("R1");
        step("R1");
        rst = 0;
        check("R1", "cfg_rdata reset", cfg_rdata, 8'h20);
        check("R1", "flag_rdata reset", flag_rdata, 8'h00);
        check("R1", "irq_pin_o reset", {7'b0, irq_pin_o}, 8'h00);
        check("R1", "irq_pin_oe reset", {7'b0, irq_pin_oe}, 8'h01);

        // R3: disabled event sets flag only
        ev_alarm = 1; step("R3"); ev_alarm = 0;
        check("R3", "flag alarm", flag_rdata, 8'h02);
        check("R3", "pin stays low", {7'b0, irq_pin_o}, 8'h00);
        step("R3");

        // R4: read clears
        flag_rd = 1; step("R4"); flag_rd = 0;
        check("R4", "flags after read", flag_rdata, 8'h00);

        // R5: level mode holds until read
        write_cfg(8'h21, "R5");
        ev_wdog = 1; step("R5"); ev_wdog = 0;
        check("R5", "level active", {7'b0, irq_pin_o}, 8'h01);
        for (int i = 0; i < 6; i++) begin
            tick = 1; step("R5");
        end
        tick = 0;
        check("R5", "level held", {7'b0, irq_pin_o}, 8'h01);
        flag_rd = 1; step("R5"); flag_rd = 0;
        check("R5", "level released", {7'b0, irq_pin_o}, 8'h00);

        // R4: read and event in the same cycle
        ev_wdog = 1; step("R4"); ev_wdog = 0;
        flag_rd = 1; ev_pfail = 1; step("R4"); flag_rd = 0; ev_pfail = 0;
        check("R4", "event beats read", flag_rdata, 8'h04);
        flag_rd = 1; step("R4"); flag_rd = 0;

        // R6: pulse width in ticks, read does not shorten it
        write_cfg(8'h31, "R6");
        ev_wdog = 1; step("R6"); ev_wdog = 0;
        check("R6", "pulse start", {7'b0, irq_pin_o}, 8'h01);
        for (int i = 0; i < PT - 1; i++) begin
            tick = 1; flag_rd = (i == 1); step("R6");
        end
        flag_rd = 0;
        check("R6", "pulse before last tick", {7'b0, irq_pin_o}, 8'h01);
        step("R6");
        tick = 1; step("R6"); tick = 0;
        check("R6", "pulse ended", {7'b0, irq_pin_o}, 8'h00);

        // R7: retrigger reloads the count
        ev_wdog = 1; step("R7"); ev_wdog = 0;
        for (int i = 0; i < 3; i++) begin
            tick = 1; step("R7");
        end
        ev_wdog = 1; tick = 1; step("R7"); ev_wdog = 0;
        for (int i = 0; i < PT - 1; i++) begin
            tick = 1; step("R7");
        end
        check("R7", "retriggered still active", {7'b0, irq_pin_o}, 8'h01);
        tick = 1; step("R7"); tick = 0;
        check("R7", "retriggered ends", {7'b0, irq_pin_o}, 8'h00);

        // R8: open-drain drive
        write_cfg(8'h11, "R8");
        check("R8", "od idle oe", {7'b0, irq_pin_oe}, 8'h00);
        ev_wdog = 1; step("R8"); ev_wdog = 0;
        check("R8", "od active oe", {7'b0, irq_pin_oe}, 8'h01);
        check("R8", "od data low", {7'b0, irq_pin_o}, 8'h00);

        // R9: reserved bits masked
        write_cfg(8'hFF, "R9");
        check("R9", "reserved masked", cfg_rdata, 8'h37);
        flag_rd = 1; step("R4"); flag_rd = 0;

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            ev_wdog   = ($urandom_range(0, 15) == 0);
            ev_alarm  = ($urandom_range(0, 15) == 0);
            ev_pfail  = ($urandom_range(0, 15) == 0);
            tick      = ($urandom_range(0, 1) == 0);
            flag_rd   = ($urandom_range(0, 19) == 0);
            cfg_wr_en = ($urandom_range(0, 49) == 0);
            cfg_wdata = 8'($urandom);
            step(m_cfg[4] ? "R6" : "R5");
        end
        idle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule